// File: doc/BRIEF.md
# Mobile Handover Decision Controller

This block sits in the medium-access layer of a mobile terminal and decides when to start a handover to a neighbouring base station. Once per frame it receives a quality sample for the serving station and for the best neighbour. It checks whether the neighbour is ahead by at least a programmable hysteresis margin. When that advantage holds over a programmable number of consecutive samples, it asks the message layer to send a handover request and starts a response timer.

If a response message arrives while the timer runs, the block asks for a handover indication to be sent. It then waits for a resume message before it returns to normal tracking. If the timer runs out first, the attempt is abandoned. A holdoff count then suppresses new triggers for a programmable number of frames.

The block does not encode messages, and it does not handle ranging or network re-entry. It only issues send requests with a type code and reports its state.

Top module: `ho_decider`

## Requirements
- R1: A sample passes only when the neighbour quality is strictly greater than the serving quality and the saturating difference (neighbour minus serving, unsigned 8-bit, 0.5 dB units) is at least `thresh_cfg`. A neighbour below the serving station never passes, even when a plain subtraction would wrap to a large value.
- R2: A handover request is triggered on the `dwell_cfg`-th consecutive passing sample, and a `dwell_cfg` of 0 or 1 triggers on the first one. While fewer passing samples have been seen, `state_o` reads 1 (candidate).
- R3: A failing sample taken in the normal or candidate state returns `state_o` to 0 (normal) and clears the consecutive-sample count.
- R4: The trigger raises `send_req` for exactly the one cycle after the triggering sample's clock edge, with `send_type` = 1 (request). In that same cycle `state_o` becomes 2 (waiting).
- R5: If no response has arrived within `rsp_tmo_cfg` cycles of entering the waiting state (at least one cycle), the controller returns to state 0. It sends nothing and loads the holdoff count from `holdoff_cfg`.
- R6: A message with `msg_type` = 1 (response) in the waiting state raises `send_req` for one cycle with `send_type` = 2 (indication) and moves to state 3 (indication). A response on the timer's last cycle wins over the timeout.
- R7: After an abandoned attempt, the next `holdoff_cfg` samples cannot start a trigger. `holdoff_o` is high while any of them remain.
- R8: State 3 is left only on a message with `msg_type` = 2 (resume), which returns the controller to state 0.
- R9: Messages in states 0 and 1 have no effect. Samples in states 2 and 3 have no effect. A message type other than 1 has no effect in state 2.
- R10: After reset, `state_o` is 0, `send_req` is 0 and `holdoff_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe marking a new quality sample pair |
| serv_q | input | 8 | Serving station quality, 0.5 dB units |
| nbr_q | input | 8 | Best neighbour quality, 0.5 dB units |
| thresh_cfg | input | 8 | Hysteresis margin, 0.5 dB units |
| dwell_cfg | input | DWELL_W | Consecutive passing samples needed to trigger |
| rsp_tmo_cfg | input | TMO_W | Response window in clock cycles |
| holdoff_cfg | input | HOLD_W | Samples blocked after an abandoned attempt |
| msg_valid | input | 1 | One-cycle strobe marking an arrived message |
| msg_type | input | 2 | Arrived message type: 1 response, 2 resume |
| send_req | output | 1 | One-cycle request to transmit a message |
| send_type | output | 2 | Type of message to send: 1 request, 2 indication |
| state_o | output | 2 | 0 normal, 1 candidate, 2 waiting, 3 indication |
| holdoff_o | output | 1 | High while new triggers are suppressed |

## Verification
The response to a request and the expiry of the response timer can fall in the same cycle. A response may also arrive just after expiry. The bench provokes the first case by placing the response strobe exactly on the last cycle of the programmed window. It then expects the indication pulse and state 3, with no holdoff loaded. For the second case, it runs the same window without a response, confirms the abort and the raised holdoff, and then delivers a late response. That response must leave the controller in state 0 with no send.

// File: rtl/ho_pkg.sv
package ho_pkg;

  localparam int Q_W = 8;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_CAND   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_HOIND  = 2'd3
  } ho_state_e;

  localparam logic [1:0] MSG_RSP    = 2'd1;
  localparam logic [1:0] MSG_RESUME = 2'd2;
  localparam logic [1:0] SEND_REQ   = 2'd1;
  localparam logic [1:0] SEND_IND   = 2'd2;

  // neighbour advantage, clamped at zero when the neighbour is not ahead
  function automatic logic [Q_W-1:0] sat_margin(input logic [Q_W-1:0] nbr,
                                                input logic [Q_W-1:0] serv);
    return (nbr > serv) ? (nbr - serv) : '0;
  endfunction

  function automatic logic margin_ok(input logic [Q_W-1:0] margin,
                                     input logic [Q_W-1:0] thresh);
    return (margin != '0) && (margin >= thresh);
  endfunction

endpackage

// File: rtl/ho_margin.sv
module ho_margin
  import ho_pkg::*;
(
  input  logic [Q_W-1:0] nbr_q,
  input  logic [Q_W-1:0] serv_q,
  input  logic [Q_W-1:0] thresh,
  output logic [Q_W-1:0] margin,
  output logic           pass
);

  always_comb begin
    margin = sat_margin(nbr_q, serv_q);
    pass   = margin_ok(margin, thresh);
  end

endmodule

// File: rtl/ho_countdown.sv
module ho_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         nz
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (dec && nz)      cnt <= cnt - 1'b1;
  end

  assign nz = (cnt != '0);

endmodule

// File: rtl/ho_decider.sv
module ho_decider
  import ho_pkg::*;
#(
  parameter int DWELL_W = 8,
  parameter int TMO_W   = 16,
  parameter int HOLD_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               meas_valid,
  input  logic [Q_W-1:0]     serv_q,
  input  logic [Q_W-1:0]     nbr_q,
  input  logic [Q_W-1:0]     thresh_cfg,
  input  logic [DWELL_W-1:0] dwell_cfg,
  input  logic [TMO_W-1:0]   rsp_tmo_cfg,
  input  logic [HOLD_W-1:0]  holdoff_cfg,
  input  logic               msg_valid,
  input  logic [1:0]         msg_type,
  output logic               send_req,
  output logic [1:0]         send_type,
  output logic [1:0]         state_o,
  output logic               holdoff_o
);

  localparam logic [DWELL_W-1:0] DWELL_MAX = {DWELL_W{1'b1}};

  function automatic logic [DWELL_W-1:0] dwell_inc(input logic [DWELL_W-1:0] c);
    return (c == DWELL_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic dwell_reached(input logic [DWELL_W-1:0] c,
                                         input logic [DWELL_W-1:0] cfg);
    return ({1'b0, c} + 1'b1) >= {1'b0, cfg};
  endfunction

  function automatic logic tmo_last(input logic [TMO_W-1:0] t);
    return t <= {{(TMO_W-1){1'b0}}, 1'b1};
  endfunction

  ho_state_e          st_q, st_d;
  logic [DWELL_W-1:0] dwell_q, dwell_d;
  logic               send_req_d;
  logic [1:0]         send_type_q, send_type_d;
  logic [Q_W-1:0]     margin;
  logic [TMO_W-1:0]   tmr_cnt;
  logic               tmr_nz;
  logic [HOLD_W-1:0]  hold_cnt;
  logic               hold_nz;

  // named internal events
  logic ev_pass, ev_sample_ok, ev_trigger, ev_rsp, ev_expire, ev_abort, ev_resume;

  ho_margin i_margin (
    .nbr_q (nbr_q),
    .serv_q(serv_q),
    .thresh(thresh_cfg),
    .margin(margin),
    .pass  (ev_pass)
  );

  assign ev_sample_ok = meas_valid &&
                        (((st_q == ST_NORMAL) && !hold_nz) || (st_q == ST_CAND));
  assign ev_trigger   = ev_sample_ok && ev_pass && dwell_reached(dwell_q, dwell_cfg);
  assign ev_rsp       = (st_q == ST_WAIT) && msg_valid && (msg_type == MSG_RSP);
  assign ev_expire    = (st_q == ST_WAIT) && tmo_last(tmr_cnt);
  assign ev_abort     = ev_expire && !ev_rsp;
  assign ev_resume    = (st_q == ST_HOIND) && msg_valid && (msg_type == MSG_RESUME);

  ho_countdown #(.W(TMO_W)) i_rsp_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_trigger),
    .load_val(rsp_tmo_cfg),
    .dec     ((st_q == ST_WAIT) && !ev_rsp && !ev_expire),
    .cnt     (tmr_cnt),
    .nz      (tmr_nz)
  );

  ho_countdown #(.W(HOLD_W)) i_holdoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_abort),
    .load_val(holdoff_cfg),
    .dec     (meas_valid && (st_q == ST_NORMAL)),
    .cnt     (hold_cnt),
    .nz      (hold_nz)
  );

  always_comb begin
    st_d        = st_q;
    dwell_d     = dwell_q;
    send_req_d  = 1'b0;
    send_type_d = send_type_q;
    unique case (st_q)
      ST_NORMAL, ST_CAND: begin
        if (ev_sample_ok) begin
          if (!ev_pass) begin
            st_d    = ST_NORMAL;
            dwell_d = '0;
          end else if (ev_trigger) begin
            st_d        = ST_WAIT;
            dwell_d     = '0;
            send_req_d  = 1'b1;
            send_type_d = SEND_REQ;
          end else begin
            st_d    = ST_CAND;
            dwell_d = dwell_inc(dwell_q);
          end
        end
      end
      ST_WAIT: begin
        if (ev_rsp) begin
          st_d        = ST_HOIND;
          send_req_d  = 1'b1;
          send_type_d = SEND_IND;
        end else if (ev_abort) begin
          st_d = ST_NORMAL;
        end
      end
      ST_HOIND: begin
        if (ev_resume) st_d = ST_NORMAL;
      end
      default: st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_NORMAL;
      dwell_q     <= '0;
      send_req    <= 1'b0;
      send_type_q <= '0;
    end else begin
      st_q        <= st_d;
      dwell_q     <= dwell_d;
      send_req    <= send_req_d;
      send_type_q <= send_type_d;
    end
  end

  assign send_type = send_type_q;
  assign state_o   = st_q;
  assign holdoff_o = hold_nz;

endmodule

// File: rtl/ho_decider_chk.sv
module ho_decider_chk
  import ho_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meas_valid,
  input logic              msg_valid,
  input logic [1:0]        msg_type,
  input logic [HOLD_W-1:0] holdoff_cfg,
  input logic              send_req,
  input logic [1:0]        send_type,
  input logic [1:0]        state_o,
  input logic              holdoff_o,
  input logic              ev_rsp,
  input logic              ev_abort
);

  p_req_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && send_type == SEND_REQ) |-> $past(meas_valid));

  p_req_enters_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && send_type == SEND_REQ) |-> (state_o == 2'd2));

  p_ind_needs_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && send_type == SEND_IND) |->
      ($past(msg_valid && msg_type == MSG_RSP) && state_o == 2'd3));

  p_abort_loads_holdoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 2'd2 && state_o == 2'd0 && $past(holdoff_cfg) != '0) |-> holdoff_o);

  p_holdoff_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && holdoff_o && meas_valid) |=> (state_o == 2'd0));

  p_ind_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !(msg_valid && msg_type == MSG_RESUME)) |=> (state_o == 2'd3));

  p_rsp_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp |=> (state_o == 2'd3 && !holdoff_o));

  p_abort_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!send_req && state_o == 2'd0));

endmodule

bind ho_decider ho_decider_chk #(.HOLD_W(HOLD_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .meas_valid (meas_valid),
  .msg_valid  (msg_valid),
  .msg_type   (msg_type),
  .holdoff_cfg(holdoff_cfg),
  .send_req   (send_req),
  .send_type  (send_type),
  .state_o    (state_o),
  .holdoff_o  (holdoff_o),
  .ev_rsp     (ev_rsp),
  .ev_abort   (ev_abort)
);

// File: tb/test_ho_decider.sv
module test_ho_decider;

  localparam int DWELL_W = 8;
  localparam int TMO_W   = 16;
  localparam int HOLD_W  = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               meas_valid = 1'b0;
  logic [7:0]         serv_q = '0, nbr_q = '0, thresh_cfg = 8'd6;
  logic [DWELL_W-1:0] dwell_cfg = 8'd3;
  logic [TMO_W-1:0]   rsp_tmo_cfg = 16'd100;
  logic [HOLD_W-1:0]  holdoff_cfg = 8'd2;
  logic               msg_valid = 1'b0;
  logic [1:0]         msg_type = '0;
  logic               send_req;
  logic [1:0]         send_type;
  logic [1:0]         state_o;
  logic               holdoff_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ho_decider #(.DWELL_W(DWELL_W), .TMO_W(TMO_W), .HOLD_W(HOLD_W)) i_ho_decider (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .serv_q(serv_q), .nbr_q(nbr_q),
    .thresh_cfg(thresh_cfg), .dwell_cfg(dwell_cfg), .rsp_tmo_cfg(rsp_tmo_cfg),
    .holdoff_cfg(holdoff_cfg), .msg_valid(msg_valid), .msg_type(msg_type),
    .send_req(send_req), .send_type(send_type), .state_o(state_o), .holdoff_o(holdoff_o)
  );

  // {serv, nbr, expected state, expected request pulse}; thresh 6, dwell 3
  localparam logic [18:0] VECS [0:6] = '{
    {8'd100, 8'd104, 2'd0, 1'b0},   // R1 margin 4 below threshold
    {8'd100, 8'd106, 2'd1, 1'b0},   // R1 margin equal to threshold passes, R2 count 1
    {8'd100, 8'd110, 2'd1, 1'b0},   // R2 count 2
    {8'd200, 8'd10,  2'd0, 1'b0},   // R1 no wrap, R3 reset count
    {8'd100, 8'd106, 2'd1, 1'b0},   // R2 count 1 again
    {8'd100, 8'd200, 2'd1, 1'b0},   // R2 count 2
    {8'd50,  8'd60,  2'd2, 1'b1}    // R2 R4 third sample triggers
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input logic [7:0] s, input logic [7:0] n);
    @(negedge clk);
    serv_q = s; nbr_q = n; meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic msg(input logic [1:0] t);
    @(negedge clk);
    msg_type = t; msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 state", state_o, 0);
    check("R10 send_req", send_req, 0);
    check("R10 holdoff", holdoff_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      meas(VECS[i][18:11], VECS[i][10:3]);
      check($sformatf("R2 row%0d state", i), state_o, VECS[i][2:1]);
      check($sformatf("R4 row%0d send_req", i), send_req, VECS[i][0]);
      if (VECS[i][0]) check("R4 send_type", send_type, 1);
    end

    // R9: sample and non-response message ignored while waiting
    meas(8'd10, 8'd100);
    check("R9 sample in wait state", state_o, 2);
    check("R9 sample in wait send", send_req, 0);
    msg(2'd2);
    check("R9 resume in wait", state_o, 2);
    msg(2'd1);
    check("R6 ind send_req", send_req, 1);
    check("R6 ind type", send_type, 2);
    check("R6 ind state", state_o, 3);
    meas(8'd10, 8'd100);
    check("R8 sample in ind", state_o, 3);
    msg(2'd2);
    check("R8 resume", state_o, 0);

    // R5: timeout with dwell 1, window 4 cycles, then late response ignored
    dwell_cfg = 8'd1; rsp_tmo_cfg = 16'd4;
    meas(8'd100, 8'd120);
    check("R2 dwell1 trigger", send_req, 1);
    check("R4 wait", state_o, 2);
    repeat (2) @(negedge clk);
    check("R5 still waiting k+2", state_o, 2);
    @(negedge clk);
    check("R5 still waiting k+3", state_o, 2);
    @(negedge clk);
    check("R5 abort state", state_o, 0);
    check("R5 abort no send", send_req, 0);
    check("R7 holdoff raised", holdoff_o, 1);
    msg_type = 2'd1; msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
    check("R9 late rsp state", state_o, 0);
    check("R9 late rsp send", send_req, 0);

    // R7: two blocked samples, third triggers
    meas(8'd100, 8'd120);
    check("R7 blocked1 state", state_o, 0);
    check("R7 blocked1 holdoff", holdoff_o, 1);
    meas(8'd100, 8'd120);
    check("R7 blocked2 state", state_o, 0);
    check("R7 holdoff cleared", holdoff_o, 0);
    meas(8'd100, 8'd120);
    check("R7 trigger after holdoff", state_o, 2);

    // R6: response on the last cycle of the window beats the timeout
    repeat (2) @(negedge clk);
    msg(2'd1);
    check("R6 collision state", state_o, 3);
    check("R6 collision send", send_req, 1);
    check("R6 collision type", send_type, 2);
    check("R6 collision holdoff", holdoff_o, 0);
    msg(2'd2);
    check("R8 resume again", state_o, 0);

    // R9: response while normal is ignored
    msg(2'd1);
    check("R9 rsp in normal state", state_o, 0);
    check("R9 rsp in normal send", send_req, 0);

    done = 1'b1;
    finish_run();
  end

endmodule